// File: doc/BRIEF.md
# Group-Address Hash Filter

This block decides whether a received frame whose destination address is a group (multicast) address should be kept. It watches the receive byte stream and runs the Ethernet CRC-32 over the six destination address bytes. The top six bits of the CRC then serve as an index into a 64-bit hash table. The indexed table bit gives the accept or reject answer. Software programs the table through two 32-bit words that can be written and read back. The answer comes out one cycle after the last address byte as a single-cycle valid pulse, together with a flag that says whether the address was a group address at all.

Frames arrive as bytes qualified by a valid strobe, with a marker on the first destination byte. Bytes past the address, idle gaps and stray bytes are skipped until the next marker. Unicast addresses are not looked up: the block still pulses valid, reports "not a group address" and never accepts them.

Top module: `mcast_hash_filter`

## Requirements
- R1: After reset both 32-bit table words read back as zero, and no decision is pending (`dec_valid`, `dec_accept` and `dec_is_group` are 0).
- R2: A write with `cfg_wr_sel` = 0 loads table word 0 and with `cfg_wr_sel` = 1 loads word 1. The written value reads back on `cfg_rd_data` (word chosen by `cfg_rd_sel`) from the next cycle on.
- R3: The hash index h[5:0] is CRC bits [31:26] after the six destination bytes. The CRC is the standard CRC-32 (polynomial 0x04C11DB7), started at all ones, with each byte fed least significant bit first, and it is taken before the final inversion. The first destination byte is the one marked by `rx_first`.
- R4: h[5:4] picks a 16-bit group: 0 is word 0 bits [15:0], 1 is word 0 bits [31:16], 2 is word 1 bits [15:0], 3 is word 1 bits [31:16]. h[3:0] picks the bit inside the group, so the tested bit is word h[5], position h[4:0].
- R5: `dec_valid` is high for exactly one cycle, namely the cycle after the sixth destination byte is taken.
- R6: `dec_is_group` equals bit 0 of the first destination byte. When that bit is 0, `dec_accept` is 0 whatever the table holds.
- R7: A byte with `rx_valid` and `rx_first` both high starts a new address at any time, and any partly received address is dropped.
- R8: Cycles with `rx_valid` low are skipped inside an address. Bytes after the sixth and before the next `rx_first` produce no decision.
- R9: A table write in the same cycle as the sixth byte does not affect that decision. The lookup uses the table contents from before the write.
- R10: `dec_accept` is high only while both `dec_valid` and `dec_is_group` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_wr_en | input | 1 | Table word write strobe |
| cfg_wr_sel | input | 1 | Table word selected for writing |
| cfg_wr_data | input | 32 | Table word write value |
| cfg_rd_sel | input | 1 | Table word selected for read-back |
| cfg_rd_data | output | 32 | Read-back value of the selected word |
| rx_valid | input | 1 | Receive byte qualifier |
| rx_first | input | 1 | Marks the first destination address byte |
| rx_data | input | 8 | Receive byte |
| dec_valid | output | 1 | One-cycle decision strobe |
| dec_accept | output | 1 | Frame passes the group filter |
| dec_is_group | output | 1 | Destination was a group address |

## Verification
The assertions assume that `rx_first` only matters when `rx_valid` is high, and that a new address never begins within one cycle of a decision. Because an address takes six bytes, the single-cycle decision pulse can be checked without a gap. They also assume the inputs are stable around the clock edge. The bench changes every input on the falling edge only. It always marks the first byte of each address and holds `rx_first` low on every other byte, including the trailing ones, so the restart and the ignore paths are reached only when a test intends it.

// File: rtl/mhf_pkg.sv
package mhf_pkg;
  localparam int unsigned CRC_W  = 32;
  localparam int unsigned BYTE_W = 8;
  localparam logic [CRC_W-1:0] CRC_POLY = 32'h04C1_1DB7;
  localparam logic [CRC_W-1:0] CRC_SEED = 32'hFFFF_FFFF;

  typedef logic [CRC_W-1:0]  crc_t;
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/mhf_rst_sync.sv
module mhf_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/mhf_crc_byte.sv
// One byte of CRC-32, least significant data bit first, unrolled per bit.
module mhf_crc_byte
  import mhf_pkg::*;
(
  input  crc_t  crc_in,
  input  byte_t din,
  output crc_t  crc_out
);
  crc_t stage [0:BYTE_W];

  assign stage[0] = crc_in;

  for (genvar b = 0; b < BYTE_W; b++) begin : g_bit
    logic fb;
    assign fb           = stage[b][CRC_W-1] ^ din[b];
    assign stage[b+1]   = {stage[b][CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
  end

  assign crc_out = stage[BYTE_W];
endmodule

// File: rtl/mhf_da_track.sv
// Counts destination bytes, accumulates the CRC and raises fire on the last one.
module mhf_da_track
  import mhf_pkg::*;
#(
  parameter int DA_BYTES  = 6,
  parameter int HASH_BITS = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rx_valid,
  input  logic                 rx_first,
  input  byte_t                rx_data,
  output logic                 fire,
  output logic [HASH_BITS-1:0] hash,
  output logic                 is_group
);
  localparam int CNT_W = $clog2(DA_BYTES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DA_BYTES);

  logic [CNT_W-1:0] cnt_q, cnt_n;
  crc_t             crc_q, crc_n, crc_base, crc_step;
  logic             grp_q, grp_n;
  logic             take;

  assign crc_base = rx_first ? CRC_SEED : crc_q;

  mhf_crc_byte u_crc (
    .crc_in  (crc_base),
    .din     (rx_data),
    .crc_out (crc_step)
  );

  // Next-state logic.
  always_comb begin
    take  = rx_valid & (rx_first | ((cnt_q != '0) & (cnt_q != CNT_LAST)));
    cnt_n = cnt_q;
    crc_n = crc_q;
    grp_n = grp_q;
    if (take) begin
      crc_n = crc_step;
      if (rx_first) begin
        cnt_n = CNT_W'(1);
        grp_n = rx_data[0];
      end else begin
        cnt_n = cnt_q + 1'b1;
      end
    end
  end

  // State registers, clock-enabled by take.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      crc_q <= CRC_SEED;
      grp_q <= 1'b0;
    end else if (take) begin
      cnt_q <= cnt_n;
      crc_q <= crc_n;
      grp_q <= grp_n;
    end
  end

  assign fire     = take & (cnt_n == CNT_LAST);
  assign hash     = crc_step[CRC_W-1 -: HASH_BITS];
  assign is_group = rx_first ? rx_data[0] : grp_q;

  a_r8_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_LAST);
  a_r7_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_first) |=> (cnt_q == CNT_W'(1)));
  a_r8_gap_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |=> ($stable(crc_q) && $stable(cnt_q)));
  a_r8_tail_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_first && cnt_q == CNT_LAST) |-> !fire);
endmodule

// File: rtl/mhf_table.sv
// Hash table held as NUM_REGS words that software can write and read back.
module mhf_table #(
  parameter int NUM_REGS = 2,
  parameter int REG_W    = 32,
  parameter int SEL_W    = 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [SEL_W-1:0]          wr_sel,
  input  logic [REG_W-1:0]          wr_data,
  input  logic [SEL_W-1:0]          rd_sel,
  output logic [REG_W-1:0]          rd_data,
  output logic [NUM_REGS*REG_W-1:0] bits
);
  for (genvar r = 0; r < NUM_REGS; r++) begin : g_word
    logic [REG_W-1:0] word_q;
    logic             hit;

    assign hit = wr_en & (wr_sel == SEL_W'(r));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   word_q <= '0;
      else if (hit) word_q <= wr_data;
    end

    assign bits[r*REG_W +: REG_W] = word_q;

    a_r2_word_load: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == SEL_W'(r)) |=> (bits[r*REG_W +: REG_W] == $past(wr_data)));
    a_r2_word_keep: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && wr_sel == SEL_W'(r)) |=> $stable(bits[r*REG_W +: REG_W]));
  end

  assign rd_data = bits[rd_sel*REG_W +: REG_W];
endmodule

// File: rtl/mhf_decide.sv
// Looks up the table bit and registers the one-cycle decision.
module mhf_decide #(
  parameter int HASH_BITS = 6
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        fire,
  input  logic [HASH_BITS-1:0]        hash,
  input  logic                        is_group,
  input  logic [(1<<HASH_BITS)-1:0]   tbl_bits,
  output logic                        dec_valid,
  output logic                        dec_accept,
  output logic                        dec_is_group
);
  logic valid_n, accept_n, group_n;

  always_comb begin
    valid_n  = fire;
    group_n  = fire & is_group;
    accept_n = fire & is_group & tbl_bits[hash];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_valid    <= 1'b0;
      dec_accept   <= 1'b0;
      dec_is_group <= 1'b0;
    end else begin
      dec_valid    <= valid_n;
      dec_accept   <= accept_n;
      dec_is_group <= group_n;
    end
  end

  a_r10_accept_qualified: assert property (@(posedge clk) disable iff (!rst_n)
    dec_accept |-> (dec_valid && dec_is_group));
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |=> !dec_valid);
  a_r5_one_cycle_late: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> dec_valid);
  a_r6_unicast_rejected: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !is_group) |=> (dec_valid && !dec_accept && !dec_is_group));
  a_r9_old_table_used: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && is_group) |=> (dec_accept == $past(tbl_bits[hash])));
endmodule

// File: rtl/mcast_hash_filter.sv
module mcast_hash_filter #(
  parameter  int DA_BYTES  = 6,
  parameter  int HASH_BITS = 6,
  parameter  int REG_W     = 32,
  localparam int TBL_BITS  = 1 << HASH_BITS,
  localparam int NUM_REGS  = TBL_BITS / REG_W,
  localparam int SEL_W     = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr_en,
  input  logic [SEL_W-1:0] cfg_wr_sel,
  input  logic [REG_W-1:0] cfg_wr_data,
  input  logic [SEL_W-1:0] cfg_rd_sel,
  output logic [REG_W-1:0] cfg_rd_data,
  input  logic             rx_valid,
  input  logic             rx_first,
  input  logic [7:0]       rx_data,
  output logic             dec_valid,
  output logic             dec_accept,
  output logic             dec_is_group
);
  logic                 rst_n_sync;
  logic                 fire;
  logic [HASH_BITS-1:0] hash;
  logic                 is_group;
  logic [TBL_BITS-1:0]  tbl_bits;

  mhf_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  mhf_da_track #(
    .DA_BYTES  (DA_BYTES),
    .HASH_BITS (HASH_BITS)
  ) u_track (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .rx_valid (rx_valid),
    .rx_first (rx_first),
    .rx_data  (rx_data),
    .fire     (fire),
    .hash     (hash),
    .is_group (is_group)
  );

  mhf_table #(
    .NUM_REGS (NUM_REGS),
    .REG_W    (REG_W),
    .SEL_W    (SEL_W)
  ) u_table (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .wr_en   (cfg_wr_en),
    .wr_sel  (cfg_wr_sel),
    .wr_data (cfg_wr_data),
    .rd_sel  (cfg_rd_sel),
    .rd_data (cfg_rd_data),
    .bits    (tbl_bits)
  );

  mhf_decide #(
    .HASH_BITS (HASH_BITS)
  ) u_decide (
    .clk          (clk),
    .rst_n        (rst_n_sync),
    .fire         (fire),
    .hash         (hash),
    .is_group     (is_group),
    .tbl_bits     (tbl_bits),
    .dec_valid    (dec_valid),
    .dec_accept   (dec_accept),
    .dec_is_group (dec_is_group)
  );
endmodule

// File: tb/mcast_hash_filter_bench.sv
module mcast_hash_filter_bench;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [47:0] da;
    logic [31:0] w0;
    logic [31:0] w1;
    logic        exp_group;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{48'h01_00_5E_00_00_01, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1},
    '{48'h01_00_5E_00_00_01, 32'h0000_0000, 32'h0000_0000, 1'b1},
    '{48'h33_33_00_00_00_01, 32'hAAAA_5555, 32'h0F0F_F0F0, 1'b1},
    '{48'h00_11_22_33_44_55, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0},
    '{48'hFF_FF_FF_FF_FF_FF, 32'h1234_5678, 32'h9ABC_DEF0, 1'b1},
    '{48'h01_80_C2_00_00_0E, 32'h0000_0000, 32'hFFFF_FFFF, 1'b1}
  };

  localparam logic [47:0] GRP_DAS [3] = '{
    48'h01_00_5E_7F_FF_FA, 48'h33_33_FF_12_34_56, 48'h09_00_2B_00_00_04
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_wr_en, cfg_wr_sel, cfg_rd_sel;
  logic [31:0] cfg_wr_data, cfg_rd_data;
  logic        rx_valid, rx_first;
  logic [7:0]  rx_data;
  logic        dec_valid, dec_accept, dec_is_group;

  int n_chk  = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mcast_hash_filter u_mcast_hash_filter (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_wr_en    (cfg_wr_en),
    .cfg_wr_sel   (cfg_wr_sel),
    .cfg_wr_data  (cfg_wr_data),
    .cfg_rd_sel   (cfg_rd_sel),
    .cfg_rd_data  (cfg_rd_data),
    .rx_valid     (rx_valid),
    .rx_first     (rx_first),
    .rx_data      (rx_data),
    .dec_valid    (dec_valid),
    .dec_accept   (dec_accept),
    .dec_is_group (dec_is_group)
  );

  // Reflected (right-shifting) CRC-32; the normal-order register is its bit reverse.
  function automatic logic [5:0] ref_hash(input logic [47:0] da);
    logic [31:0] r;
    logic [7:0]  b;
    r = 32'hFFFF_FFFF;
    for (int i = 0; i < 6; i++) begin
      b = da[47-8*i -: 8];
      for (int k = 0; k < 8; k++) begin
        if (r[0] ^ b[k]) r = (r >> 1) ^ 32'hEDB8_8320;
        else             r = r >> 1;
      end
    end
    return {r[0], r[1], r[2], r[3], r[4], r[5]};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic write_word(input logic sel, input logic [31:0] val);
    @(negedge clk);
    cfg_wr_en   = 1'b1;
    cfg_wr_sel  = sel;
    cfg_wr_data = val;
    @(negedge clk);
    cfg_wr_en   = 1'b0;
  endtask

  task automatic load(input logic [31:0] w0, input logic [31:0] w1);
    write_word(1'b0, w0);
    write_word(1'b1, w1);
  endtask

  // Sends six address bytes; returns at the negedge where the decision is visible.
  task automatic send_da(input logic [47:0] da, input bit gap,
                         input bit wr_last, input logic wsel, input logic [31:0] wval);
    for (int i = 0; i < 6; i++) begin
      if (gap && i > 0) begin
        @(negedge clk);
        rx_valid = 1'b0;
        rx_first = 1'b0;
      end
      @(negedge clk);
      rx_valid = 1'b1;
      rx_first = (i == 0);
      rx_data  = da[47-8*i -: 8];
      if (wr_last && i == 5) begin
        cfg_wr_en   = 1'b1;
        cfg_wr_sel  = wsel;
        cfg_wr_data = wval;
      end
    end
    @(negedge clk);
    rx_valid  = 1'b0;
    rx_first  = 1'b0;
    cfg_wr_en = 1'b0;
  endtask

  task automatic expect_dec(input string tag, input logic grp, input logic acc);
    chk({tag, " R5 valid"}, 32'(dec_valid), 32'd1);
    chk({tag, " R6 group"}, 32'(dec_is_group), 32'(grp));
    chk({tag, " R4 accept"}, 32'(dec_accept), 32'(acc));
    @(negedge clk);
    chk({tag, " R5 pulse ends"}, 32'(dec_valid), 32'd0);
    chk({tag, " R10 accept low"}, 32'(dec_accept), 32'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [5:0]  h;
    logic [63:0] tb;
    logic        acc;
    logic [31:0] one;

    rst_n = 1'b0; cfg_wr_en = 1'b0; cfg_wr_sel = 1'b0; cfg_wr_data = '0;
    cfg_rd_sel = 1'b0; rx_valid = 1'b0; rx_first = 1'b0; rx_data = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    cfg_rd_sel = 1'b0; #1;
    chk("R1 word0 reset", cfg_rd_data, 32'h0);
    cfg_rd_sel = 1'b1; #1;
    chk("R1 word1 reset", cfg_rd_data, 32'h0);
    chk("R1 no decision", {29'd0, dec_valid, dec_accept, dec_is_group}, 32'h0);

    // R2: write and read back both words
    load(32'hA5A5_0F0F, 32'h5A5A_F0F0);
    cfg_rd_sel = 1'b0; #1;
    chk("R2 word0 readback", cfg_rd_data, 32'hA5A5_0F0F);
    cfg_rd_sel = 1'b1; #1;
    chk("R2 word1 readback", cfg_rd_data, 32'h5A5A_F0F0);

    // Vector table: R3 hash, R4 lookup, R6 group flag
    for (int v = 0; v < 6; v++) begin
      load(VECS[v].w0, VECS[v].w1);
      h   = ref_hash(VECS[v].da);
      tb  = {VECS[v].w1, VECS[v].w0};
      acc = VECS[v].exp_group & tb[h];
      send_da(VECS[v].da, 1'b0, 1'b0, 1'b0, '0);
      expect_dec($sformatf("R3 vector %0d", v), VECS[v].exp_group, acc);
    end

    // R4: single-bit table at the hashed position, then its complement
    for (int k = 0; k < 3; k++) begin
      h   = ref_hash(GRP_DAS[k]);
      one = 32'd1 << h[4:0];
      if (h[5]) load(32'h0, one); else load(one, 32'h0);
      send_da(GRP_DAS[k], 1'b0, 1'b0, 1'b0, '0);
      expect_dec($sformatf("R4 only bit %0d", h), 1'b1, 1'b1);
      if (h[5]) load(32'hFFFF_FFFF, ~one); else load(~one, 32'hFFFF_FFFF);
      send_da(GRP_DAS[k], 1'b0, 1'b0, 1'b0, '0);
      expect_dec($sformatf("R4 all but bit %0d", h), 1'b1, 1'b0);
    end

    // R7: restart after a partial address
    h   = ref_hash(GRP_DAS[1]);
    one = 32'd1 << h[4:0];
    if (h[5]) load(32'h0, one); else load(one, 32'h0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      rx_valid = 1'b1;
      rx_first = (i == 0);
      rx_data  = GRP_DAS[0][47-8*i -: 8];
    end
    send_da(GRP_DAS[1], 1'b0, 1'b0, 1'b0, '0);
    expect_dec("R7 restart", 1'b1, 1'b1);

    // R8: gaps inside the address, then trailing bytes ignored
    send_da(GRP_DAS[1], 1'b1, 1'b0, 1'b0, '0);
    expect_dec("R8 gapped", 1'b1, 1'b1);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R8 trailing no decision", 32'(dec_valid), 32'd0);
      rx_valid = (i < 4);
      rx_first = 1'b0;
      rx_data  = 8'h01;
    end
    @(negedge clk);
    chk("R8 trailing no decision", 32'(dec_valid), 32'd0);

    // R9: table write in the sixth-byte cycle uses the old contents
    send_da(GRP_DAS[1], 1'b0, 1'b1, h[5], 32'h0);
    expect_dec("R9 old table", 1'b1, 1'b1);
    send_da(GRP_DAS[1], 1'b0, 1'b0, 1'b0, '0);
    expect_dec("R9 new table", 1'b1, 1'b0);

    // R6/R10: unicast with full table never accepted
    load(32'hFFFF_FFFF, 32'hFFFF_FFFF);
    send_da(48'h02_00_00_00_00_01, 1'b0, 1'b0, 1'b0, '0);
    expect_dec("R6 R10 unicast", 1'b0, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule